// File: doc/BRIEF.md
# DAC Serial Command Receiver

This block is the device-side serial slave of a single-channel 12-bit digital-to-analog converter. A host shifts 16-bit command words over a three-wire SPI-compatible link made of a serial clock, a data line and an active-low select. The three serial lines are brought into a faster system clock through two-flop synchronisers, and their edges are detected in that domain. A word is taken in most significant bit first.

When the select line returns high after exactly sixteen serial clock edges, the upper four bits are decoded as an opcode and the lower twelve as data. Depending on the opcode, the block loads a holding (input) register, copies it into the DAC register, or loads both at once. Power-mode requests are passed on as one-cycle strobes, together with a 2-bit reference selection, to a separate power-mode controller. A frame of any other length is thrown away.

Top module: `dac_serial_rx`

## Requirements
- R1: After reset, dac_code_o is 0 (zero scale), ref_sel_o is 0, and no strobe is high.
- R2: A frame holds 16 bits, sampled on the rising edge of the serial clock while the select is low, MSB first: bits 15:12 are the opcode and bits 11:0 are the data. The command executes once, on the select's rising edge, and each strobe is high for exactly one system clock cycle.
- R3: Opcode 0000 and the reserved opcodes 0010 to 0111, 1010 and 1011 change no register and raise no strobe.
- R4: Opcode 0001 loads the data into the input register only. dac_code_o stays unchanged and no strobe is raised.
- R5: Opcode 1000 copies the input register into the DAC register and pulses load_stb_o and wake_stb_o.
- R6: Opcodes 1001 and 1111 load the data into both the input register and the DAC register, and pulse load_stb_o and wake_stb_o.
- R7: Opcode 1100 pulses standby_stb_o and sets ref_sel_o to data bits 11:10.
- R8: Opcode 1101 pulses wake_stb_o and sets ref_sel_o to data bits 11:10.
- R9: Opcode 1110 pulses shutdown_stb_o and sets ref_sel_o to data bits 11:10.
- R10: If the select rises after any number of serial clock edges other than 16, for example 15 or 17, nothing executes.
- R11: If the sixteenth serial clock edge and the select's rising edge reach the system domain in the same cycle, that edge still counts as bit 16 and the frame executes.
- R12: Serial clock edges seen while the select is high have no effect.
- R13: At most one of wake_stb_o, standby_stb_o and shutdown_stb_o is high in any cycle. dac_code_o changes only in a cycle where load_stb_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data in |
| csn_i | input | 1 | Active-low frame select |
| dac_code_o | output | 12 | DAC register contents |
| ref_sel_o | output | 2 | Last reference selection received |
| load_stb_o | output | 1 | One-cycle pulse: DAC register written |
| wake_stb_o | output | 1 | One-cycle pulse: request normal operation |
| standby_stb_o | output | 1 | One-cycle pulse: request standby |
| shutdown_stb_o | output | 1 | One-cycle pulse: request shutdown |

## Verification
Two functions can fall in the same system cycle: the capture of the last data bit and the execution triggered by the select's rising edge. The bench provokes this by raising the serial clock and the select on the same input change for the sixteenth bit. It then expects the DAC register to carry the full word, with bit 0 included. The other frames, sent with a clean gap between the last edge and the select, show that the ordinary path gives the same result. The 15-bit and 17-bit frames around them show that a count off by one is still refused.

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int DATA_W      = 12,
  parameter int OP_W        = 4,
  parameter int REF_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              load_stb_o,
  output logic              wake_stb_o,
  output logic              standby_stb_o,
  output logic              shutdown_stb_o
);

  localparam int FRAME_W = OP_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] sclk_sy, sdi_sy, csn_sy;
  logic sclk_d, csn_d;
  logic [FRAME_W-1:0] shf, shf_nx;
  logic [CNT_W-1:0]   cnt, cnt_nx;
  logic [DATA_W-1:0]  in_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      sdi_sy  <= '0;
      csn_sy  <= '1;
      sclk_d  <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      sdi_sy  <= {sdi_sy[SYNC_STAGES-2:0], sdi_i};
      csn_sy  <= {csn_sy[SYNC_STAGES-2:0], csn_i};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
      csn_d   <= csn_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_s   = sclk_sy[SYNC_STAGES-1];
  wire csn_s    = csn_sy[SYNC_STAGES-1];
  wire sdi_s    = sdi_sy[SYNC_STAGES-1];
  wire cs_open  = ~csn_s & csn_d;
  wire cs_close = csn_s & ~csn_d;
  // selection state of the previous cycle qualifies the bit, so a last edge
  // that coincides with the closing select is still captured
  wire take_bit = sclk_s & ~sclk_d & ~csn_d;

  always_comb begin
    shf_nx = take_bit ? {shf[FRAME_W-2:0], sdi_s} : shf;
    cnt_nx = cnt;
    if (cs_open)
      cnt_nx = '0;
    else if (take_bit && cnt != CNT_OVER)
      cnt_nx = cnt + CNT_W'(1);
  end

  wire [OP_W-1:0]   opcode = shf_nx[FRAME_W-1 -: OP_W];
  wire [DATA_W-1:0] data   = shf_nx[DATA_W-1:0];
  wire [REF_W-1:0]  refsel = data[DATA_W-1 -: REF_W];
  wire              fire   = cs_close && (cnt_nx == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf            <= '0;
      cnt            <= '0;
      in_reg         <= '0;
      dac_code_o     <= '0;
      ref_sel_o      <= '0;
      load_stb_o     <= 1'b0;
      wake_stb_o     <= 1'b0;
      standby_stb_o  <= 1'b0;
      shutdown_stb_o <= 1'b0;
    end else begin
      shf            <= shf_nx;
      cnt            <= cnt_nx;
      load_stb_o     <= 1'b0;
      wake_stb_o     <= 1'b0;
      standby_stb_o  <= 1'b0;
      shutdown_stb_o <= 1'b0;
      if (fire) begin
        case (opcode)
          OP_W'(4'b0001): in_reg <= data;
          OP_W'(4'b1000): begin
            dac_code_o <= in_reg;
            load_stb_o <= 1'b1;
            wake_stb_o <= 1'b1;
          end
          OP_W'(4'b1001), OP_W'(4'b1111): begin
            in_reg     <= data;
            dac_code_o <= data;
            load_stb_o <= 1'b1;
            wake_stb_o <= 1'b1;
          end
          OP_W'(4'b1100): begin
            standby_stb_o <= 1'b1;
            ref_sel_o     <= refsel;
          end
          OP_W'(4'b1101): begin
            wake_stb_o <= 1'b1;
            ref_sel_o  <= refsel;
          end
          OP_W'(4'b1110): begin
            shutdown_stb_o <= 1'b1;
            ref_sel_o      <= refsel;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_strobe_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb_o | wake_stb_o | standby_stb_o | shutdown_stb_o) |-> $past(cs_close));

  a_r10_load_needs_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb_o |-> ($past(cnt_nx) == CNT_FULL));

  a_r5_load_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb_o |-> wake_stb_o);

  a_r13_one_power_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_stb_o, standby_stb_o, shutdown_stb_o}));

  a_r13_dac_moves_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != $past(dac_code_o)) |-> load_stb_o);

  a_r12_no_count_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_d && csn_s) |=> (cnt == $past(cnt)));

endmodule

// File: tb/dac_serial_rx_test.sv
module dac_serial_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic [11:0] dac_code;
  logic [1:0]  ref_sel;
  logic ld, wk, sb, sd;

  int tests = 0, fails = 0;
  int n_ld = 0, n_wk = 0, n_sb = 0, n_sd = 0;
  int b_ld, b_wk, b_sb, b_sd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
    .dac_code_o(dac_code), .ref_sel_o(ref_sel), .load_stb_o(ld),
    .wake_stb_o(wk), .standby_stb_o(sb), .shutdown_stb_o(sd)
  );

  always @(negedge clk) if (rst_n) begin
    n_ld += int'(ld); n_wk += int'(wk); n_sb += int'(sb); n_sd += int'(sd);
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit coincide);
    b_ld = n_ld; b_wk = n_wk; b_sb = n_sb; b_sd = n_sd;
    csn = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = (i < 16) ? w[15-i] : 1'b0;
      wait_clks(HALF);
      sclk = 1'b1;
      if (coincide && i == nbits - 1) csn = 1'b1;
      wait_clks(HALF);
    end
    sclk = 1'b0;
    wait_clks(HALF);
    csn = 1'b1;
    wait_clks(10);
  endtask

  task automatic expect_all(input string req, input int dac, input int rsel,
                            input int el, input int ew, input int es, input int ed);
    chk({req, " dac_code"}, int'(dac_code), dac);
    chk({req, " ref_sel"}, int'(ref_sel), rsel);
    chk({req, " load pulses"}, n_ld - b_ld, el);
    chk({req, " wake pulses"}, n_wk - b_wk, ew);
    chk({req, " standby pulses"}, n_sb - b_sb, es);
    chk({req, " shutdown pulses"}, n_sd - b_sd, ed);
  endtask

  task automatic t_reset;
    chk("R1 dac zero", int'(dac_code), 0);
    chk("R1 ref zero", int'(ref_sel), 0);
    chk("R1 strobes low", int'({ld, wk, sb, sd}), 0);
  endtask

  task automatic t_load_then_update;
    send(16'h1ABC, 16, 0);
    expect_all("R4 input only", 0, 0, 0, 0, 0, 0);
    send(16'h8000, 16, 0);
    expect_all("R5 copy input", 'hABC, 0, 1, 1, 0, 0);
  endtask

  task automatic t_load_both;
    send(16'h9123, 16, 0);
    expect_all("R6 R2 op1001 msb first", 'h123, 0, 1, 1, 0, 0);
    send(16'hFFFF, 16, 0);
    expect_all("R6 op1111", 'hFFF, 0, 1, 1, 0, 0);
  endtask

  task automatic t_noop_reserved;
    logic [3:0] ops [10] = '{4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB, 4'h0};
    for (int k = 0; k < 9; k++) begin
      send({ops[k], 12'hD55}, 16, 0);
      expect_all($sformatf("R3 op %0h", ops[k]), 'hFFF, 0, 0, 0, 0, 0);
    end
    send(16'h8000, 16, 0);
    expect_all("R3 input kept", 'hFFF, 0, 1, 1, 0, 0);
  endtask

  task automatic t_power;
    send(16'hC800, 16, 0);
    expect_all("R7 R13 standby", 'hFFF, 2, 0, 0, 1, 0);
    send(16'hDC00, 16, 0);
    expect_all("R8 R13 normal", 'hFFF, 3, 0, 1, 0, 0);
    send(16'hE400, 16, 0);
    expect_all("R9 R13 shutdown", 'hFFF, 1, 0, 0, 0, 1);
  endtask

  task automatic t_bad_count;
    send(16'h90AA, 15, 0);
    expect_all("R10 15 bits", 'hFFF, 1, 0, 0, 0, 0);
    send(16'h90AA, 17, 0);
    expect_all("R10 17 bits", 'hFFF, 1, 0, 0, 0, 0);
    send(16'h90AA, 16, 0);
    expect_all("R10 16 bits", 'h0AA, 1, 1, 1, 0, 0);
  endtask

  task automatic t_coincide;
    send(16'h9321, 16, 1);
    expect_all("R11 coincident edge", 'h321, 1, 1, 1, 0, 0);
  endtask

  task automatic t_idle_clock;
    b_ld = n_ld; b_wk = n_wk; b_sb = n_sb; b_sd = n_sd;
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sclk = 1'b1; wait_clks(HALF);
      sclk = 1'b0; wait_clks(HALF);
    end
    wait_clks(10);
    expect_all("R12 idle clocks", 'h321, 1, 0, 0, 0, 0);
    send(16'h8000, 16, 0);
    expect_all("R12 input kept", 'h321, 1, 1, 1, 0, 0);
  endtask

  initial begin
    wait_clks(5);
    t_reset();
    rst_n = 1'b1;
    wait_clks(5);
    t_reset();
    t_load_then_update();
    t_load_both();
    t_noop_reserved();
    t_power();
    t_bad_count();
    t_coincide();
    t_idle_clock();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule